// File: doc/BRIEF.md
# PLL Self-Calibration Sequencing Controller

This controller decides when a jitter-cleaning PLL has to run its internal calibration. It also tracks the lock and holdover states around that calibration. The analog loop, the oscillator, the calibration algorithm and the frequency measurement all sit outside this block. They reach it only as handshake flags: an input-clock alarm, an active-input flag, a reference-present flag, a calibration-done pulse, a frequency-drift flag and an internal out-of-range flag.

A calibration is requested by any of the following:
- power-on reset;
- release of the active-low external reset;
- a change on the configuration select bundle, which carries frequency select, frequency table, bandwidth and reference type;
- the out-of-range flag;
- a drift flag, which marks a shift of 500 ppm or more since the last calibration.

A request is held pending until the selected input is valid and active and the reference is present. While the PLL calibrates or is otherwise unlocked, the loss-of-lock alarm is high. After a good calibration, losing the input moves the controller to holdover. When the input comes back, the controller relocks without calibrating again. An optional squelch keeps the output off from reset until the first calibration finishes.

Top module: `pll_cal_seq`

## Requirements
- R1: While `por` is high, the controller is in reset: `cal_busy`=0, `lol`=1, `holdover`=0, and `out_squelch` equals `squelch_en`.
- R2: A calibration starts only on a clock edge where `in_alarm`=0, `in_active`=1 and `ref_ok`=1. Until then the controller waits, with `cal_busy`=0 and `lol`=1.
- R3: `lol` is 1 in every state except locked, including for the whole time `cal_busy` is 1.
- R4: After a calibration completes with the input valid, the controller stays locked with `cal_busy`=0. This holds as long as no trigger occurs and the input remains valid.
- R5: Once locked, an input loss (`in_alarm`=1 or `in_active`=0) sets `holdover`=1 on the next edge. When the input returns, the controller goes back to locked on the next edge without raising `cal_busy`.
- R6: In the locked or holdover state, each of the following leads to a new calibration: a change on `cfg_sel` relative to the value captured at the last calibration start (the bundle is registered one cycle first), `range_err`=1, or `drift`=1.
- R7: While `ext_rst_n`=0, the controller stays in reset. After release it waits, then calibrates once the clocks are valid.
- R8: A trigger seen during calibration is remembered. When `cal_done` arrives, the controller returns to waiting and runs one more calibration instead of locking.
- R9: With `squelch_en`=1, `out_squelch` is 1 from reset until the `cal_done` pulse that ends the first calibration, and 0 after it. With `squelch_en`=0, `out_squelch` is 0.
- R10: If `cal_done` arrives while `in_alarm`=1 and no trigger is queued, the calibration ends in holdover rather than locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| ext_rst_n | input | 1 | External reset, active low, sampled on the clock |
| cfg_sel | input | CFG_W | Configuration select bundle: frequency, table, bandwidth, reference type |
| range_err | input | 1 | Internal loop registers out of range |
| in_alarm | input | 1 | Selected input clock alarm, 1 = invalid |
| in_active | input | 1 | Selected input is the active clock |
| ref_ok | input | 1 | Reference clock or crystal present |
| cal_done | input | 1 | One-cycle pulse when calibration finishes |
| drift | input | 1 | Input frequency moved 500 ppm or more since last calibration |
| squelch_en | input | 1 | Enable output squelch until first calibration |
| cal_busy | output | 1 | Calibration running |
| lol | output | 1 | Loss-of-lock alarm |
| holdover | output | 1 | Holdover indicator |
| out_squelch | output | 1 | Hold output clock off |

## Verification
The assertions assume that `cal_done` is a single-cycle pulse that only appears while a calibration is running. They also assume that `cfg_sel` stays stable for at least two cycles before a calibration starts, so that the registered copy matches the pins. The bench drives every input on the falling edge, keeps `cal_done` to one-cycle pulses inside calibration, and holds `cfg_sel` constant across each bring-up. It changes `cfg_sel` only in the scenarios that test trigger detection.

// File: rtl/pll_cal_seq.sv
module pll_cal_seq #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             por,
  input  logic             ext_rst_n,
  input  logic [CFG_W-1:0] cfg_sel,
  input  logic             range_err,
  input  logic             in_alarm,
  input  logic             in_active,
  input  logic             ref_ok,
  input  logic             cal_done,
  input  logic             drift,
  input  logic             squelch_en,
  output logic             cal_busy,
  output logic             lol,
  output logic             holdover,
  output logic             out_squelch
);

  typedef enum logic [2:0] {ST_RESET, ST_WAIT, ST_CAL, ST_LOCK, ST_HOLD} st_t;

  st_t              state;
  logic [CFG_W-1:0] cfg_q, cfg_cap;
  logic             requeue, sq;

  wire in_ok  = !in_alarm && in_active;
  wire clk_ok = in_ok && ref_ok;
  wire trig   = (cfg_q != cfg_cap) || range_err || drift;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      state   <= ST_RESET;
      cfg_q   <= '0;
      cfg_cap <= '0;
      requeue <= 1'b0;
      sq      <= 1'b1;
    end else begin
      cfg_q <= cfg_sel;
      if (!ext_rst_n) begin
        state   <= ST_RESET;
        requeue <= 1'b0;
        sq      <= 1'b1;
      end else begin
        case (state)
          ST_RESET: state <= ST_WAIT;
          ST_WAIT:
            if (clk_ok) begin
              state   <= ST_CAL;
              cfg_cap <= cfg_q;
              requeue <= 1'b0;
            end
          ST_CAL:
            if (cal_done) begin
              sq <= 1'b0;
              if (requeue || trig) state <= ST_WAIT;
              else if (in_alarm)   state <= ST_HOLD;
              else                 state <= ST_LOCK;
            end else if (trig) begin
              requeue <= 1'b1;
            end
          ST_LOCK:
            if (trig)        state <= ST_WAIT;
            else if (!in_ok) state <= ST_HOLD;
          ST_HOLD:
            if (trig)       state <= ST_WAIT;
            else if (in_ok) state <= ST_LOCK;
          default: state <= ST_RESET;
        endcase
      end
    end
  end

  assign cal_busy    = (state == ST_CAL);
  assign lol         = (state != ST_LOCK);
  assign holdover    = (state == ST_HOLD);
  assign out_squelch = sq && squelch_en;

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (por)
    $rose(cal_busy) |-> $past(clk_ok && ext_rst_n));

  assert_reset_hold_R7: assert property (@(posedge clk) disable iff (por)
    !ext_rst_n |=> (state == ST_RESET && !cal_busy && lol));

  assert_stay_locked_R4: assert property (@(posedge clk) disable iff (por)
    (state == ST_LOCK && !trig && in_ok && ext_rst_n) |=> (state == ST_LOCK));

  assert_relock_no_cal_R5: assert property (@(posedge clk) disable iff (por)
    (state == ST_HOLD && !trig && in_ok && ext_rst_n) |=> (!lol && !cal_busy));

  assert_done_alarm_R10: assert property (@(posedge clk) disable iff (por)
    (state == ST_CAL && cal_done && !requeue && !trig && in_alarm && ext_rst_n)
      |=> holdover);

  assert_requeue_R8: assert property (@(posedge clk) disable iff (por)
    (state == ST_CAL && cal_done && requeue && ext_rst_n) |=> (state == ST_WAIT));

  assert_squelch_release_R9: assert property (@(posedge clk) disable iff (por)
    $fell(sq) |-> $past(cal_done && state == ST_CAL));

endmodule

// File: tb/pll_cal_seq_tb.sv
module pll_cal_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 8;

  logic clk = 1'b0;
  logic por, ext_rst_n, range_err, in_alarm, in_active, ref_ok, cal_done, drift, squelch_en;
  logic [CFG_W-1:0] cfg_sel;
  logic cal_busy, lol, holdover, out_squelch;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_cal_seq #(.CFG_W(CFG_W)) u_dut (
    .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .cfg_sel(cfg_sel),
    .range_err(range_err), .in_alarm(in_alarm), .in_active(in_active),
    .ref_ok(ref_ok), .cal_done(cal_done), .drift(drift), .squelch_en(squelch_en),
    .cal_busy(cal_busy), .lol(lol), .holdover(holdover), .out_squelch(out_squelch));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bring_up(input logic sq_en);
    por = 1'b1; ext_rst_n = 1'b1; cfg_sel = 8'h35; range_err = 1'b0;
    in_alarm = 1'b0; in_active = 1'b1; ref_ok = 1'b1; cal_done = 1'b0;
    drift = 1'b0; squelch_en = sq_en;
    cyc(2);
    por = 1'b0;
    cyc(1);
  endtask

  task automatic lock_up();
    bring_up(1'b1);
    cyc(1);
    cal_done = 1'b1; cyc(1); cal_done = 1'b0;
  endtask

  task automatic t_reset();
    por = 1'b1; squelch_en = 1'b1; ext_rst_n = 1'b1;
    cyc(2);
    chk("R1", "busy in por", cal_busy, 1'b0);
    chk("R1", "lol in por", lol, 1'b1);
    chk("R1", "holdover in por", holdover, 1'b0);
    chk("R1", "squelch in por", out_squelch, 1'b1);
  endtask

  task automatic t_gating();
    bring_up(1'b0);
    ref_ok = 1'b0;
    cyc(1);
    ref_ok = 1'b1; in_active = 1'b0;
    cyc(3);
    chk("R2", "busy without active input", cal_busy, 1'b0);
    chk("R2", "lol while waiting", lol, 1'b1);
    in_active = 1'b1; in_alarm = 1'b1;
    cyc(2);
    chk("R2", "busy with alarm", cal_busy, 1'b0);
    in_alarm = 1'b0;
    cyc(1);
    chk("R2", "busy once clocks ok", cal_busy, 1'b1);
    chk("R3", "lol during cal", lol, 1'b1);
  endtask

  task automatic t_lock_stable();
    lock_up();
    for (int i = 0; i < 8; i++) begin
      chk("R4", "stays locked lol", lol, 1'b0);
      chk("R4", "no recal busy", cal_busy, 1'b0);
      cyc(1);
    end
  endtask

  task automatic t_holdover();
    lock_up();
    in_alarm = 1'b1;
    cyc(1);
    chk("R5", "holdover on loss", holdover, 1'b1);
    chk("R3", "lol in holdover", lol, 1'b1);
    in_alarm = 1'b0;
    cyc(1);
    chk("R5", "relocked", lol, 1'b0);
    chk("R5", "no cal on relock", cal_busy, 1'b0);
    chk("R5", "holdover cleared", holdover, 1'b0);
    in_active = 1'b0;
    cyc(1);
    chk("R5", "holdover on inactive", holdover, 1'b1);
    in_active = 1'b1;
    cyc(1);
    chk("R5", "relock after inactive", lol, 1'b0);
  endtask

  task automatic t_triggers();
    lock_up();
    cfg_sel = 8'h36;
    cyc(2);
    chk("R6", "cfg change leaves lock", lol, 1'b1);
    cyc(1);
    chk("R6", "cfg change recal", cal_busy, 1'b1);
    cal_done = 1'b1; cyc(1); cal_done = 1'b0;
    chk("R6", "locked after cfg recal", lol, 1'b0);
    drift = 1'b1; cyc(1); drift = 1'b0;
    cyc(1);
    chk("R6", "drift recal", cal_busy, 1'b1);
    cal_done = 1'b1; cyc(1); cal_done = 1'b0;
    in_alarm = 1'b1; cyc(1);
    chk("R6", "holdover before range", holdover, 1'b1);
    in_alarm = 1'b0; range_err = 1'b1; cyc(1); range_err = 1'b0;
    chk("R6", "range from holdover leaves", holdover, 1'b0);
    cyc(1);
    chk("R6", "range recal", cal_busy, 1'b1);
  endtask

  task automatic t_ext_reset();
    lock_up();
    ext_rst_n = 1'b0;
    cyc(3);
    chk("R7", "lol in ext reset", lol, 1'b1);
    chk("R7", "no busy in ext reset", cal_busy, 1'b0);
    chk("R7", "squelch reasserted", out_squelch, 1'b1);
    ext_rst_n = 1'b1;
    cyc(1);
    chk("R7", "waiting after release", cal_busy, 1'b0);
    cyc(1);
    chk("R7", "cal after release", cal_busy, 1'b1);
  endtask

  task automatic t_requeue();
    bring_up(1'b0);
    cyc(1);
    chk("R8", "in cal", cal_busy, 1'b1);
    cfg_sel = 8'h00;
    cyc(3);
    cal_done = 1'b1; cyc(1); cal_done = 1'b0;
    chk("R8", "no lock after queued change", lol, 1'b1);
    chk("R8", "waiting", cal_busy, 1'b0);
    cyc(1);
    chk("R8", "second cal", cal_busy, 1'b1);
    cal_done = 1'b1; cyc(1); cal_done = 1'b0;
    chk("R8", "locks after second", lol, 1'b0);
  endtask

  task automatic t_squelch();
    bring_up(1'b1);
    chk("R9", "squelch before cal", out_squelch, 1'b1);
    cyc(1);
    chk("R9", "squelch during cal", out_squelch, 1'b1);
    cal_done = 1'b1; cyc(1); cal_done = 1'b0;
    chk("R9", "squelch released", out_squelch, 1'b0);
    bring_up(1'b0);
    chk("R9", "squelch disabled", out_squelch, 1'b0);
  endtask

  task automatic t_done_alarm();
    bring_up(1'b0);
    cyc(1);
    in_alarm = 1'b1; cal_done = 1'b1; cyc(1); cal_done = 1'b0;
    chk("R10", "done with alarm to holdover", holdover, 1'b1);
    chk("R10", "busy ended", cal_busy, 1'b0);
    in_alarm = 1'b0; cyc(1);
    chk("R10", "relock after alarm", lol, 1'b0);
  endtask

  initial begin
    t_reset();
    t_gating();
    t_lock_stable();
    t_holdover();
    t_triggers();
    t_ext_reset();
    t_requeue();
    t_squelch();
    t_done_alarm();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule